// File: doc/BRIEF.md
# Clause-22 MDIO Management Master

This block talks to Ethernet PHYs over the two-wire management bus. Software sees three word registers: a command word, a data word and a combined configuration/status word. Writing the command word with the read flag set starts a read frame at once. Writing it with the flag clear arms a write, and the frame starts when the data word is next written, carrying that data. A status bit stays busy for the whole transaction. On a read, the 16 bits returned by the PHY land in the data word. A separate flag reports a PHY that did not drive the turnaround.

The management clock comes from a programmable divider. It holds each half period for `div` system clocks, so MDC = f_clk / (2 × div). Software picks `div = f_clk / f_mdc / 2`. Values below a floor are refused.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy and the read-error flag read 0, MDC is low, MDIO is not driven, and the divider reads `RST_DIV` (default 4).
- R2: A write frame is 64 bits, MSB first: 32 ones, start `01`, opcode `01`, 5-bit PHY address, 5-bit register address, turnaround `10`, then the 16 data bits. The master drives all 64 bits.
- R3: After a write command, no MDC edge occurs and busy stays 1 until the data word (address 1) is written. The frame then carries bits [15:0] of that write.
- R4: A read frame drives 46 bits: 32 ones, `01`, opcode `10`, the PHY address and the register address. The master then releases MDIO for the turnaround and the 16 data bits.
- R5: On read completion, the data word (address 1, bits [15:0]) holds the 16 bits sampled on the MDC rising edges of frame bits 48..63, MSB first.
- R6: The read-error flag (status bit 30) is set at read completion when MDIO is high at the rising edge of frame bit 47. Any accepted command clears it.
- R7: MDIO changes only while MDC is low. Each MDC half period lasts `div` clocks, so busy lasts exactly 128 × `div` clocks for a read.
- R8: A configuration write (address 2) with bits [DIV_W-1:0] below `MIN_DIV` (default 2) leaves the divider unchanged.
- R9: A command write while busy is ignored: the command word (address 0) keeps its value.
- R10: When not busy, MDC is low and MDIO is not driven.

Register map: address 0 is the command word, with bits [4:0] the register address, [9:5] the PHY address and [15] the read flag. Address 1 is the data word. Address 2 holds the divider in [DIV_W-1:0], busy in bit 31 and the read error in bit 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Resolved MDIO line value |

## Verification
The hardest cases to reach are those that depend on the PHY's timing. One is the read-error path, which needs a PHY that stays silent exactly at frame bit 47 while still answering the data bits. Another is the held write, where the data word arrives many cycles after the command.

The bench models the PHY on the MDC edges. It counts rising edges to track the frame position, and on chosen reads it withholds its turnaround drive. Random transactions mix reads and writes, divider values and delays before the data write. Directed cases add a command issued while busy and a divider write below the floor.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_REL     = 46;   // first bit released on a read
    localparam int TA_CHK     = 47;   // bit the PHY must pull low
    localparam int DATA_FIRST = 48;
    localparam int LAST_BIT   = FRAME_BITS - 1;

    localparam logic [1:0] A_CMD  = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_CFG  = 2'd2;

    typedef struct packed {
        logic                  active;
        logic                  is_rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sreg;
        logic                  oe;
        logic [15:0]           rdata;
        logic                  ta_bad;
    } eng_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic rd, input logic [4:0] phy, input logic [4:0] regad,
        input logic [15:0] dat);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, regad,
                (rd ? 2'b11 : 2'b10), dat};
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t gen_d, gen_q;
    logic wrap;

    always_comb begin
        gen_d = gen_q;
        wrap  = (gen_q.cnt == div - 1'b1);
        if (!run) begin
            gen_d.cnt = '0;
            gen_d.mdc = 1'b0;
        end else if (wrap) begin
            gen_d.cnt = '0;
            gen_d.mdc = ~gen_q.mdc;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign mdc  = gen_q.mdc;
    assign rise = run && wrap && !gen_q.mdc;
    assign fall = run && wrap &&  gen_q.mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_rd,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  mdio_i,
    output logic                  active,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic [15:0]           rdata,
    output logic                  ta_bad
);
    eng_t eng_d, eng_q;
    logic [IDX_W-1:0] nxt_idx;

    always_comb begin
        eng_d   = eng_q;
        done    = 1'b0;
        nxt_idx = eng_q.idx + 1'b1;
        if (start) begin
            eng_d.active = 1'b1;
            eng_d.is_rd  = start_rd;
            eng_d.idx    = '0;
            eng_d.sreg   = frame;
            eng_d.oe     = 1'b1;
            eng_d.rdata  = '0;
            eng_d.ta_bad = 1'b0;
        end else if (eng_q.active) begin
            if (rise && eng_q.is_rd) begin
                if (eng_q.idx == IDX_W'(TA_CHK))
                    eng_d.ta_bad = mdio_i;
                else if (eng_q.idx >= IDX_W'(DATA_FIRST))
                    eng_d.rdata = {eng_q.rdata[14:0], mdio_i};
            end
            if (fall) begin
                if (eng_q.idx == IDX_W'(LAST_BIT)) begin
                    eng_d.active = 1'b0;
                    eng_d.oe     = 1'b0;
                    done         = 1'b1;
                end else begin
                    eng_d.idx  = nxt_idx;
                    eng_d.sreg = {eng_q.sreg[FRAME_BITS-2:0], 1'b0};
                    if (eng_q.is_rd && nxt_idx >= IDX_W'(TA_REL))
                        eng_d.oe = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign active  = eng_q.active;
    assign mdio_o  = eng_q.sreg[FRAME_BITS-1];
    assign mdio_oe = eng_q.oe;
    assign rdata   = eng_q.rdata;
    assign ta_bad  = eng_q.ta_bad;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int RST_DIV = 4,
    parameter int MIN_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic             cmd_rd;
        logic [4:0]       cmd_phy;
        logic [4:0]       cmd_reg;
        logic [15:0]      data;
        logic [DIV_W-1:0] div;
        logic             busy;
        logic             pend_wr;
        logic             rerr;
    } regs_t;

    regs_t rg_d, rg_q;
    logic start, start_rd, done, active, rise, fall, ta_bad;
    logic [FRAME_BITS-1:0] frame;
    logic [15:0] rdata;
    logic wcmd, wdat, wcfg;
    logic busy_w;
    logic [DIV_W-1:0] div_w;
    logic [15:0] cmd_w;

    always_comb begin
        rg_d     = rg_q;
        start    = 1'b0;
        start_rd = 1'b0;
        frame    = '0;
        wcmd     = wr_en && (wr_addr == A_CMD);
        wdat     = wr_en && (wr_addr == A_DATA);
        wcfg     = wr_en && (wr_addr == A_CFG);
        if (done) begin
            rg_d.busy = 1'b0;
            if (rg_q.cmd_rd) begin
                rg_d.data = rdata;
                rg_d.rerr = ta_bad;
            end
        end
        if (wcmd && !rg_q.busy) begin
            rg_d.cmd_rd  = wr_data[15];
            rg_d.cmd_phy = wr_data[9:5];
            rg_d.cmd_reg = wr_data[4:0];
            rg_d.busy    = 1'b1;
            rg_d.rerr    = 1'b0;
            if (wr_data[15]) begin
                start    = 1'b1;
                start_rd = 1'b1;
                frame    = build_frame(1'b1, wr_data[9:5], wr_data[4:0], 16'h0);
            end else begin
                rg_d.pend_wr = 1'b1;
            end
        end
        if (wdat) begin
            rg_d.data = wr_data[15:0];
            if (rg_q.pend_wr) begin
                rg_d.pend_wr = 1'b0;
                start        = 1'b1;
                frame        = build_frame(1'b0, rg_q.cmd_phy, rg_q.cmd_reg,
                                           wr_data[15:0]);
            end
        end
        if (wcfg && !rg_q.busy && (wr_data[DIV_W-1:0] >= DIV_W'(MIN_DIV)))
            rg_d.div = wr_data[DIV_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q     <= '0;
            rg_q.div <= DIV_W'(RST_DIV);
        end else begin
            rg_q <= rg_d;
        end
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .run(active), .div(rg_q.div),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
        .frame(frame), .rise(rise), .fall(fall), .mdio_i(mdio_i),
        .active(active), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
        .rdata(rdata), .ta_bad(ta_bad)
    );

    assign busy_w = rg_q.busy;
    assign div_w  = rg_q.div;
    assign cmd_w  = {rg_q.cmd_rd, 5'b0, rg_q.cmd_phy, rg_q.cmd_reg};

    always_comb begin
        case (rd_addr)
            A_CMD:   rd_data = {16'h0, cmd_w};
            A_DATA:  rd_data = {16'h0, rg_q.data};
            A_CFG:   rd_data = {rg_q.busy, rg_q.rerr, {(30-DIV_W){1'b0}}, rg_q.div};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int DIV_W   = 8,
    parameter int MIN_DIV = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             busy,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [DIV_W-1:0] div,
    input logic [15:0]      cmd
);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));
    a_r7_change_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc);
    a_r4_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> !mdc);
    a_r8_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
        div >= DIV_W'(MIN_DIV));
    a_r9_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == 2'd0) |=> $stable(cmd));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .busy(busy_w), .wr_en(wr_en), .wr_addr(wr_addr), .div(div_w), .cmd(cmd_w)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/100ps
module tb_mdio_master;
    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic mdc, mdio_o, mdio_oe, mdio_i;

    int total = 0, bad = 0;
    bit finished = 0;

    // PHY model state
    logic cap_clr = 1'b0;
    logic [63:0] cap;
    int ncap, k;
    logic phy_en, phy_val;
    logic rd_mode = 1'b0, ta_good = 1'b1;
    logic [15:0] resp = '0;
    int cur_div = 4;

    always #2.5 clk = ~clk;

    mdio_master dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    always @(posedge mdc or posedge cap_clr) begin
        if (cap_clr) begin
            cap <= '0; ncap <= 0; k <= 0;
        end else begin
            if (mdio_oe) begin
                cap <= {cap[62:0], mdio_o};
                ncap <= ncap + 1;
            end
            k <= k + 1;
        end
    end

    always @(negedge mdc or posedge cap_clr) begin
        if (cap_clr) phy_en <= 1'b0;
        else if (rd_mode && k == 47) begin
            phy_en <= ta_good; phy_val <= 1'b0;
        end else if (rd_mode && k >= 48 && k <= 63) begin
            phy_en <= 1'b1; phy_val <= resp[63-k];
        end else phy_en <= 1'b0;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a; #0.5; v = rd_data;
    endtask

    task automatic clear_cap();
        cap_clr = 1'b1; #0.1; cap_clr = 1'b0;
    endtask

    function automatic logic [31:0] cmd_word(input bit rd, input logic [4:0] p,
                                             input logic [4:0] r);
        return {16'h0, rd, 5'b0, p, r};
    endfunction

    function automatic logic [63:0] exp_wr(input logic [4:0] p, input logic [4:0] r,
                                           input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    endfunction

    function automatic logic [45:0] exp_rd(input logic [4:0] p, input logic [4:0] r);
        return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
    endfunction

    task automatic poll_idle(output int cnt);
        logic [31:0] s;
        cnt = 0;
        forever begin
            bus_rd(2'd2, s);
            if (!s[31]) break;
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic do_read(input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] rv, input bit good, input bit intrude);
        int cnt;
        logic [31:0] v;
        rd_mode = 1'b1; resp = rv; ta_good = good;
        clear_cap();
        bus_wr(2'd0, cmd_word(1'b1, p, r));
        if (intrude) begin
            bus_wr(2'd0, cmd_word(1'b0, ~p, ~r));
            bus_rd(2'd0, v);
            chk(v == cmd_word(1'b1, p, r), "R9 cmd write while busy", v, cmd_word(1'b1, p, r));
        end
        poll_idle(cnt);
        if (!intrude)
            chk(cnt == 128*cur_div, "R7 busy length", cnt, 128*cur_div);
        chk(ncap == 46, "R4 driven bit count", ncap, 46);
        chk(cap[45:0] == exp_rd(p, r), "R4 read header", cap[45:0], exp_rd(p, r));
        bus_rd(2'd1, v);
        chk(v == {16'h0, rv}, "R5 read data", v, {16'h0, rv});
        bus_rd(2'd2, v);
        chk(v[30] == !good, "R6 read error flag", v[30], !good);
        rd_mode = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] p, input logic [4:0] r,
                            input logic [15:0] d, input int gap);
        int cnt;
        bit held = 1;
        logic [31:0] v;
        rd_mode = 1'b0;
        clear_cap();
        bus_wr(2'd0, cmd_word(1'b0, p, r));
        bus_rd(2'd2, v);
        chk(v[30] == 1'b0, "R6 flag cleared by command", v[30], 0);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            bus_rd(2'd2, v);
            if (mdc || !v[31]) held = 0;
        end
        chk(held && ncap == 0, "R3 write held for data", {held, 32'(ncap)}, 1 << 32);
        bus_wr(2'd1, {16'hABCD, d});
        poll_idle(cnt);
        chk(ncap == 64, "R2 driven bit count", ncap, 64);
        chk(cap == exp_wr(p, r, d), "R2 write frame", cap, exp_wr(p, r, d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unused;
        unused = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(2'd2, v);
        chk(v == 32'd4, "R1 status after reset", v, 32'd4);
        chk(!mdc && !mdio_oe, "R1 pins after reset", {mdc, mdio_oe}, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 idle pins", {mdc, mdio_oe}, 0);

        bus_wr(2'd2, 32'd1);
        bus_rd(2'd2, v);
        chk(v[7:0] == 8'd4, "R8 divider below floor", v[7:0], 4);
        bus_wr(2'd2, 32'd0);
        bus_rd(2'd2, v);
        chk(v[7:0] == 8'd4, "R8 divider zero", v[7:0], 4);
        bus_wr(2'd2, 32'd2); cur_div = 2;
        bus_rd(2'd2, v);
        chk(v[7:0] == 8'd2, "R8 divider at floor", v[7:0], 2);

        do_read(5'h1F, 5'h00, 16'h8001, 1'b1, 1'b0);
        do_write(5'h00, 5'h1F, 16'h0000, 0);
        do_read(5'h03, 5'h11, 16'hBEEF, 1'b0, 1'b0);
        do_write(5'h05, 5'h0A, 16'hFFFF, 25);
        do_read(5'h0C, 5'h02, 16'h1234, 1'b1, 1'b1);

        for (int t = 0; t < 14; t++) begin
            logic [4:0] p, r;
            logic [15:0] d;
            int dv;
            p = 5'($urandom); r = 5'($urandom); d = 16'($urandom);
            dv = 2 + int'($urandom % 2);
            bus_wr(2'd2, 32'(dv)); cur_div = dv;
            if ($urandom % 2) do_read(p, r, d, ($urandom % 4) != 0, 1'b0);
            else do_write(p, r, d, int'($urandom % 12));
        end

        chk(!mdc && !mdio_oe, "R10 idle after traffic", {mdc, mdio_oe}, 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule